// File: doc/BRIEF.md
# SD Card SPI-Mode Responder

This block plays the card end of an SD link in SPI mode. A host drives chip select, a serial clock that idles high, and command/data bits on MOSI. The block answers on MISO. It decodes six-byte command frames and walks a card through the power-up handshake: reset, interface condition, and the application-command poll. It then accepts single-block writes into an internal sector buffer and serves single-block reads back from it. A read names a block address, and it succeeds only when that address matches the last sector written.

The serial pins are sampled on the block's own clock `clk_i`. The host's serial clock edges are found by comparing each sample of `sck_i` with the previous one. Both directions work in whole byte times. While the host clocks in one byte, the block shifts out the byte its response sequencer picked at the previous byte boundary. Idle byte times read as 0xFF.

Top module: `sdspi_card`

## Requirements
- R1: `miso_o` is 1 after reset and in every cycle in which `cs_ni` has been high since the previous cycle. During the command frame bytes and the gap byte, the block returns 0xFF.
- R2: A frame is six bytes, MSB first. The first byte has bits [7:6] = 01 and carries the command index in bits [5:0]. The next four bytes are the 32-bit argument, most significant byte first. The sixth byte, the CRC, is ignored. While the block waits for a frame, it skips bytes whose top bits are not 01. The response byte arrives in the second byte time after the frame, with exactly one 0xFF byte between them.
- R3: Index 0 is answered with 0x01. It returns the card to the initialising state and clears the poll count.
- R4: Index 8 is answered with 0x01 while initialising, or 0x00 when ready. Four more bytes follow: 0x00, 0x00, {4'h0, arg[11:8]}, arg[7:0].
- R5: Index 55 is answered with 0x01 while initialising, or 0x00 when ready. Index 41 sent directly after index 55 counts as a poll. The first INIT_POLLS-1 polls since reset or index 0 return 0x01. The INIT_POLLS-th poll returns 0x00 and makes the card ready, and later polls return 0x00.
- R6: The block answers 0x04 to index 17 or 24 while the card is initialising, to index 41 not directly after index 55, and to any index not listed here.
- R7: A write (index 24, card ready) is answered with 0x00. After that the block returns 0xFF and ignores incoming bytes until a 0xFE token arrives. It then stores the next SECTOR_BYTES bytes in order and ignores two CRC bytes. The byte after the CRC carries 0x05, followed by BUSY_CYCLES/8 bytes of 0x00 and then 0xFF. The argument becomes the stored sector address.
- R8: A read (index 17, card ready) whose argument equals the stored sector address is answered with 0x00. Then come 0xFE, the stored bytes in order, and two 0xFF bytes.
- R9: A read while the card is ready is answered with 0x00 and then 0x08 in place of data, then 0xFF, in two cases: no sector has been written yet, or the argument differs from the stored address.
- R10: Raising `cs_ni` drops any partly received byte, frame or transfer. The first full frame after `cs_ni` falls again is decoded normally.
- R11: MOSI is sampled on rising `sck_i`. `miso_o` changes only after falling `sck_i` or while `cs_ni` is high. Each `sck_i` phase lasts at least 3 `clk_i` cycles, and all serial inputs are synchronous to `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host, idles high |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |

## Verification
The bench builds the block with SECTOR_BYTES=128, INIT_POLLS=3 and BUSY_CYCLES=40. The shorter sector lets several complete write and read transfers fit in the run, each one reaching the last byte of the sector and the CRC bytes after it. Three polls exercise both the 0x01 and 0x00 answers of the initialisation loop. Five busy bytes check that the busy count is honoured rather than fixed at one byte. The same parameters reach the address-mismatch and not-yet-written error paths, a reset command after the card is ready, and aborts on a partial bit and on a partial frame.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
  typedef enum logic [3:0] {
    ST_CMD, ST_GAP, ST_R1, ST_TAIL, ST_TOK, ST_RDATA, ST_CRC, ST_ERR,
    ST_WTOK, ST_WDATA, ST_WCRC, ST_DRESP, ST_BUSY
  } st_e;

  typedef enum logic [2:0] {RK_PLAIN, RK_TAIL, RK_READ, RK_RERR, RK_WRITE} rkind_e;

  localparam logic [7:0] BYTE_IDLE  = 8'hFF;
  localparam logic [7:0] TOK_START  = 8'hFE;
  localparam logic [7:0] TOK_ACCEPT = 8'h05;
  localparam logic [7:0] TOK_DERR   = 8'h08;
  localparam logic [7:0] R1_READY   = 8'h00;
  localparam logic [7:0] R1_INIT    = 8'h01;
  localparam logic [7:0] R1_ILLEGAL = 8'h04;

  localparam logic [5:0] IX_RESET  = 6'd0;
  localparam logic [5:0] IX_IFCOND = 6'd8;
  localparam logic [5:0] IX_READ   = 6'd17;
  localparam logic [5:0] IX_WRITE  = 6'd24;
  localparam logic [5:0] IX_OPCOND = 6'd41;
  localparam logic [5:0] IX_APP    = 6'd55;
endpackage

// File: rtl/sdspi_link.sv
module sdspi_link #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              miso_o
);
  localparam int CW = $clog2(BYTE_W);

  logic              sck_q;
  logic [CW-1:0]     bit_cnt_q;
  logic [BYTE_W-2:0] rx_sh_q;
  logic [BYTE_W-2:0] tx_sh_q;
  logic              rise_w, fall_w;

  assign rise_w = sck_i & ~sck_q & ~cs_ni;
  assign fall_w = ~sck_i & sck_q & ~cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b1;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '1;
      miso_o      <= 1'b1;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '1;
    end else begin
      sck_q       <= sck_i;
      byte_done_o <= 1'b0;
      if (cs_ni) begin
        bit_cnt_q <= '0;
        tx_sh_q   <= '1;
        miso_o    <= 1'b1;
      end else begin
        if (rise_w) begin
          rx_sh_q   <= {rx_sh_q[BYTE_W-3:0], mosi_i};
          bit_cnt_q <= bit_cnt_q + CW'(1);
          if (bit_cnt_q == CW'(BYTE_W-1)) begin
            byte_done_o <= 1'b1;
            rx_byte_o   <= {rx_sh_q, mosi_i};
          end
        end
        if (fall_w) begin
          // byte boundary: take the sequencer's next byte
          if (bit_cnt_q == '0) begin
            miso_o  <= tx_byte_i[BYTE_W-1];
            tx_sh_q <= tx_byte_i[BYTE_W-2:0];
          end else begin
            miso_o  <= tx_sh_q[BYTE_W-2];
            tx_sh_q <= {tx_sh_q[BYTE_W-3:0], 1'b1};
          end
        end
      end
    end
  end

  AST_BYTE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !byte_done_o); // R11
  AST_MISO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miso_o) |-> ($past(fall_w) || $past(cs_ni))); // R11
endmodule

// File: rtl/sdspi_sector.sv
module sdspi_sector #(
  parameter int DEPTH  = 512,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sdspi_card.sv
module sdspi_card
  import sdspi_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int INIT_POLLS   = 2,
  parameter int BUSY_CYCLES  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int AW         = $clog2(SECTOR_BYTES);
  localparam int BUSY_BYTES = (BUSY_CYCLES + 7) / 8;
  localparam int CW         = $clog2(BUSY_BYTES + 4);
  localparam int PW         = $clog2(INIT_POLLS + 1);

  logic          byte_done;
  logic [7:0]    rx_byte, tx_q, rdata;
  st_e           state_q;
  rkind_e        kind_q;
  logic [7:0]    r1_q;
  logic [37:0]   frm_q;
  logic [2:0]    fcnt_q;
  logic [31:0]   tail_q, warg_q, addr_q;
  logic [AW-1:0] idx_q, raddr;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] polls_q;
  logic          ready_q, app_q, valid_q, we;
  logic [5:0]    dec_ix;
  logic [31:0]   dec_arg;

  sdspi_link u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .cs_ni(cs_ni), .mosi_i(mosi_i),
    .tx_byte_i(tx_q), .byte_done_o(byte_done), .rx_byte_o(rx_byte), .miso_o(miso_o)
  );

  assign we    = byte_done && (state_q == ST_WDATA) && !cs_ni;
  assign raddr = (state_q == ST_RDATA) ? idx_q + AW'(1) : idx_q;

  sdspi_sector #(.DEPTH(SECTOR_BYTES)) u_sector (
    .clk_i(clk_i), .we_i(we), .waddr_i(idx_q), .wdata_i(rx_byte),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  assign dec_ix  = frm_q[37:32];
  assign dec_arg = frm_q[31:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;   kind_q  <= RK_PLAIN; r1_q   <= BYTE_IDLE;
      frm_q   <= '0;       fcnt_q  <= '0;       tail_q <= '0;
      warg_q  <= '0;       addr_q  <= '0;       idx_q  <= '0;
      cnt_q   <= '0;       polls_q <= '0;       tx_q   <= BYTE_IDLE;
      ready_q <= 1'b0;     app_q   <= 1'b0;     valid_q <= 1'b0;
    end else if (cs_ni) begin
      state_q <= ST_CMD;
      fcnt_q  <= '0;
      tx_q    <= BYTE_IDLE;
    end else if (byte_done) begin
      unique case (state_q)
        ST_CMD: begin
          if (fcnt_q == 3'd0) begin
            if (rx_byte[7:6] == 2'b01) begin
              frm_q  <= {32'h0, rx_byte[5:0]};
              fcnt_q <= 3'd1;
            end
          end else if (fcnt_q != 3'd5) begin
            frm_q  <= {frm_q[29:0], rx_byte};
            fcnt_q <= fcnt_q + 3'd1;
          end else begin
            // sixth byte is the CRC: decode the stored frame
            fcnt_q  <= '0;
            state_q <= ST_GAP;
            tx_q    <= BYTE_IDLE;
            kind_q  <= RK_PLAIN;
            app_q   <= 1'b0;
            r1_q    <= R1_ILLEGAL;
            case (dec_ix)
              IX_RESET: begin
                r1_q <= R1_INIT; ready_q <= 1'b0; polls_q <= '0;
              end
              IX_IFCOND: begin
                r1_q   <= ready_q ? R1_READY : R1_INIT;
                kind_q <= RK_TAIL;
                tail_q <= {20'h0, dec_arg[11:0]};
              end
              IX_APP: begin
                r1_q  <= ready_q ? R1_READY : R1_INIT;
                app_q <= 1'b1;
              end
              IX_OPCOND: begin
                if (app_q) begin
                  if (ready_q || polls_q == PW'(INIT_POLLS-1)) begin
                    ready_q <= 1'b1; r1_q <= R1_READY;
                  end else begin
                    polls_q <= polls_q + PW'(1); r1_q <= R1_INIT;
                  end
                end
              end
              IX_READ: if (ready_q) begin
                r1_q   <= R1_READY;
                kind_q <= (valid_q && dec_arg == addr_q) ? RK_READ : RK_RERR;
              end
              IX_WRITE: if (ready_q) begin
                r1_q <= R1_READY; kind_q <= RK_WRITE; warg_q <= dec_arg;
              end
              default: ;
            endcase
          end
        end
        ST_GAP: begin tx_q <= r1_q; state_q <= ST_R1; end
        ST_R1: begin
          idx_q <= '0;
          cnt_q <= '0;
          unique case (kind_q)
            RK_TAIL:  begin tx_q <= tail_q[31:24]; tail_q <= {tail_q[23:0], 8'h0}; state_q <= ST_TAIL; end
            RK_READ:  begin tx_q <= TOK_START; state_q <= ST_TOK; end
            RK_RERR:  begin tx_q <= TOK_DERR;  state_q <= ST_ERR; end
            RK_WRITE: begin tx_q <= BYTE_IDLE; state_q <= ST_WTOK; end
            default:  begin tx_q <= BYTE_IDLE; state_q <= ST_CMD; end
          endcase
        end
        ST_TAIL: begin
          if (cnt_q == CW'(3)) begin
            tx_q <= BYTE_IDLE; state_q <= ST_CMD;
          end else begin
            tx_q <= tail_q[31:24]; tail_q <= {tail_q[23:0], 8'h0}; cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_TOK: begin tx_q <= rdata; state_q <= ST_RDATA; end
        ST_RDATA: begin
          if (idx_q == AW'(SECTOR_BYTES-1)) begin
            tx_q <= BYTE_IDLE; cnt_q <= '0; state_q <= ST_CRC;
          end else begin
            tx_q <= rdata; idx_q <= idx_q + AW'(1);
          end
        end
        ST_CRC: begin
          if (cnt_q == CW'(1)) state_q <= ST_CMD;
          else cnt_q <= cnt_q + CW'(1);
        end
        ST_ERR: begin tx_q <= BYTE_IDLE; state_q <= ST_CMD; end
        ST_WTOK: if (rx_byte == TOK_START) begin idx_q <= '0; state_q <= ST_WDATA; end
        ST_WDATA: begin
          if (idx_q == AW'(SECTOR_BYTES-1)) begin
            valid_q <= 1'b1; addr_q <= warg_q; cnt_q <= '0; state_q <= ST_WCRC;
          end else begin
            idx_q <= idx_q + AW'(1);
          end
        end
        ST_WCRC: begin
          if (cnt_q == CW'(1)) begin tx_q <= TOK_ACCEPT; state_q <= ST_DRESP; end
          else cnt_q <= cnt_q + CW'(1);
        end
        ST_DRESP: begin tx_q <= 8'h00; cnt_q <= '0; state_q <= ST_BUSY; end
        ST_BUSY: begin
          if (cnt_q == CW'(BUSY_BYTES-1)) begin tx_q <= BYTE_IDLE; state_q <= ST_CMD; end
          else cnt_q <= cnt_q + CW'(1);
        end
        default: begin tx_q <= BYTE_IDLE; state_q <= ST_CMD; end
      endcase
    end
  end

  AST_READY_AFTER_APP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(app_q)); // R5
  AST_WRITE_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WTOK) |-> ready_q); // R6
  AST_READ_NEEDS_SECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDATA) |-> valid_q); // R8
  AST_CS_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (state_q == ST_CMD)); // R10
endmodule

// File: tb/sdspi_card_test.sv
module sdspi_card_test;
  localparam int SB = 128;
  localparam int IP = 3;
  localparam int BC = 40;
  localparam int BB = (BC + 7) / 8;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b1, cs = 1'b1, mosi = 1'b1;
  logic miso;
  int   nrun = 0, nfail = 0;

  int         m_ready = 0, m_polls = 0, m_app = 0, m_valid = 0;
  logic [31:0] m_addr = '0;
  logic [7:0]  m_mem [SB];

  always #10 clk = ~clk;

  sdspi_card #(.SECTOR_BYTES(SB), .INIT_POLLS(IP), .BUSY_CYCLES(BC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs), .mosi_i(mosi), .miso_o(miso)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    nrun++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  // R1 monitor: cs high for two samples in a row -> miso must be 1
  logic cs_seen = 1'b0;
  always @(posedge clk) begin
    #2;
    if (rst_n && cs && cs_seen && miso !== 1'b1) begin
      nfail++;
      $display("FAIL R1 miso with cs high got %b exp 1", miso);
    end
    cs_seen = cs;
  end

  task automatic bit_xfer(input logic b, output logic r);
    @(negedge clk); sck = 1'b0; mosi = b;
    repeat (3) @(negedge clk);
    r = miso; sck = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] o, input logic [7:0] exp, input string req);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) bit_xfer(o[i], r[i]);
    check(r, exp, req);
  endtask

  task automatic do_cmd(input logic [5:0] ix, input logic [31:0] arg, input int seed, input string req);
    logic [7:0] r1, crc;
    int kind = 0; // 0 plain 1 tail 2 read 3 rerr 4 write
    crc = (ix == 6'd0) ? 8'h95 : (ix == 6'd8) ? 8'h87 : 8'hFF;
    xbyte({2'b01, ix}, 8'hFF, "R1");
    for (int k = 3; k >= 0; k--) xbyte(arg[8*k +: 8], 8'hFF, "R1");
    xbyte(crc, 8'hFF, "R1");
    xbyte(8'hFF, 8'hFF, "R2");
    case (ix)
      6'd0:  begin r1 = 8'h01; m_ready = 0; m_polls = 0; end
      6'd8:  begin r1 = m_ready ? 8'h00 : 8'h01; kind = 1; end
      6'd55: r1 = m_ready ? 8'h00 : 8'h01;
      6'd41: if (m_app) begin
               if (!m_ready) begin m_polls++; if (m_polls >= IP) m_ready = 1; end
               r1 = m_ready ? 8'h00 : 8'h01;
             end else r1 = 8'h04;
      6'd17: if (!m_ready) r1 = 8'h04;
             else begin r1 = 8'h00; kind = (m_valid && arg == m_addr) ? 2 : 3; end
      6'd24: if (!m_ready) r1 = 8'h04; else begin r1 = 8'h00; kind = 4; end
      default: r1 = 8'h04;
    endcase
    m_app = (ix == 6'd55);
    xbyte(8'hFF, r1, req);
    case (kind)
      1: begin
        xbyte(8'hFF, 8'h00, "R4"); xbyte(8'hFF, 8'h00, "R4");
        xbyte(8'hFF, {4'h0, arg[11:8]}, "R4"); xbyte(8'hFF, arg[7:0], "R4");
      end
      2: begin
        xbyte(8'hFF, 8'hFE, "R8");
        for (int i = 0; i < SB; i++) xbyte(8'hFF, m_mem[i], "R8");
        xbyte(8'hFF, 8'hFF, "R8"); xbyte(8'hFF, 8'hFF, "R8");
      end
      3: xbyte(8'hFF, 8'h08, "R9");
      4: begin
        xbyte(8'hFF, 8'hFF, "R7");
        xbyte(8'hFE, 8'hFF, "R7");
        for (int i = 0; i < SB; i++) begin
          m_mem[i] = 8'((i * seed + 11) & 255);
          xbyte(m_mem[i], 8'hFF, "R7");
        end
        m_valid = 1; m_addr = arg;
        xbyte(8'hFF, 8'hFF, "R7"); xbyte(8'hFF, 8'hFF, "R7");
        xbyte(8'hFF, 8'h05, "R7");
        for (int i = 0; i < BB; i++) xbyte(8'hFF, 8'h00, "R7");
      end
      default: ;
    endcase
    xbyte(8'hFF, 8'hFF, "R1");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    logic r;
    repeat (5) @(negedge clk);
    check({7'h0, miso}, 8'h01, "R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cs = 1'b0;
    repeat (3) @(negedge clk);
    do_cmd(6'd17, 32'd6000, 0, "R6 read before init");
    xbyte(8'h3F, 8'hFF, "R2 skip"); xbyte(8'hA5, 8'hFF, "R2 skip");
    do_cmd(6'd0, 32'h0, 0, "R3 R11 reset cmd");
    do_cmd(6'd8, 32'h1AA, 0, "R4 ifcond init");
    do_cmd(6'd24, 32'd6000, 0, "R6 write before init");
    for (int p = 0; p < IP; p++) begin
      do_cmd(6'd55, 32'h0, 0, "R5 app");
      do_cmd(6'd41, 32'h4000_0000, 0, "R5 poll");
    end
    do_cmd(6'd8, 32'h2BC, 0, "R4 ifcond ready");
    do_cmd(6'd17, 32'd6000, 0, "R9 read unwritten");
    do_cmd(6'd24, 32'd6000, 5, "R7 write");
    do_cmd(6'd17, 32'd6000, 0, "R8 read");
    do_cmd(6'd17, 32'd7000, 0, "R9 read other addr");
    do_cmd(6'd41, 32'h4000_0000, 0, "R6 poll without app");
    do_cmd(6'd9, 32'h0, 0, "R6 unknown index");
    // R10: abort mid-frame and mid-bit
    xbyte(8'h51, 8'hFF, "R10"); xbyte(8'h00, 8'hFF, "R10"); xbyte(8'h00, 8'hFF, "R10");
    @(negedge clk); cs = 1'b1; repeat (6) @(negedge clk); cs = 1'b0; repeat (3) @(negedge clk);
    bit_xfer(1'b0, r); bit_xfer(1'b1, r); bit_xfer(1'b0, r);
    @(negedge clk); cs = 1'b1; repeat (6) @(negedge clk); cs = 1'b0; repeat (3) @(negedge clk);
    do_cmd(6'd17, 32'd6000, 0, "R10 read after abort");
    do_cmd(6'd24, 32'd7000, 13, "R7 second write");
    do_cmd(6'd17, 32'd7000, 0, "R8 read second");
    do_cmd(6'd17, 32'd6000, 0, "R9 old addr");
    do_cmd(6'd0, 32'h0, 0, "R3 reset when ready");
    do_cmd(6'd17, 32'd7000, 0, "R3 R6 read after reset");
    @(negedge clk); cs = 1'b1;
    repeat (10) @(negedge clk);
    nrun++; // R1 chip-select monitor
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule